// File: doc/BRIEF.md
# Configurable Thread Slot Scheduler

This block decides, in every cycle, which hardware thread may place an instruction into one shared in-order pipeline. Each thread raises a ready flag when it has an instruction to offer. The block answers with a thread identifier and a valid flag. It raises a bubble flag instead when the cycle must go empty. The identifier travels with the issued slot, so that later stages read and write the correct per-thread state.

Three scheduling policies can be selected. A fixed rotation gives every thread one turn out of every N cycles. A slot-table rotation walks through S programmable entries, and each entry names the thread that owns that slot. A ready-driven priority policy gives the cycle to the lowest-numbered ready thread.

In both rotations, a slot whose owner is not ready becomes a bubble; no other thread may take it. A new policy is picked up only when the slot pointer wraps, so a frame never mixes two policies.

Top module: `thread_slot_sched`

## Requirements
- R1: After reset the slot pointer is 0 and the active policy is the fixed rotation. Table entry i holds thread i mod NTHR until it is written.
- R2: In the fixed rotation, the slot at pointer value k belongs to thread k mod NTHR, so each thread owns exactly one slot in every NTHR consecutive cycles. The slot is issued (issue_valid_o=1, issue_tid_o=owner) when the owner is ready.
- R3: In either rotation, when the owner of the current slot is not ready, issue_valid_o is 0 and bubble_o is 1. issue_tid_o still reports the owner, and no other thread issues in that cycle.
- R4: In the table rotation, the owner is table entry number ptr. The pointer steps 0, 1, …, NSLOT-1 and then returns to 0, one step per cycle, whatever the policy.
- R5: A cycle with tbl_we_i=1 stores tbl_data_i into entry tbl_addr_i at the clock edge. The new owner governs that slot from the next cycle on.
- R6: In the priority policy, the lowest-numbered ready thread issues. When no thread is ready, a bubble is issued with issue_tid_o=0.
- R7: mode_i is sampled only at the clock edge on which the pointer moves from NSLOT-1 to 0. A change seen at any other edge has no effect until that wrap.
- R8: mode_i encoding: 0 selects the fixed rotation, 1 the table rotation, 2 the priority policy, and 3 acts as the fixed rotation.
- R9: issue_valid_o and issue_tid_o respond to ready_i within the same cycle, with no register between them.
- R10: bubble_o is always the inverse of issue_valid_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ready_i | input | NTHR | Per-thread ready flags |
| mode_i | input | 2 | Requested policy, adopted at the pointer wrap |
| tbl_we_i | input | 1 | Slot table write enable |
| tbl_addr_i | input | log2(NSLOT) | Slot table entry to write |
| tbl_data_i | input | log2(NTHR) | Thread number to store in the entry |
| issue_valid_o | output | 1 | A thread issues this cycle |
| issue_tid_o | output | log2(NTHR) | Thread identifier sent with the slot |
| bubble_o | output | 1 | This cycle is an empty pipeline slot |

## Verification
Directed runs first use all-ready flags, which show the pure slot order of each rotation. A single ready thread then separates "insert a bubble" from "skip to the next ready thread". One directed run changes the policy request in the middle of a frame: an early switch would issue the lone ready thread in a slot that the old rotation gives to a thread that is not ready. Random ready patterns, table writes and policy requests check the priority choice, the point at which a table write takes effect, and the reserved policy code against a model of the pointer, the table and the active policy.

// File: rtl/thread_sched_pkg.sv
`timescale 1ns/1ps
package thread_sched_pkg;

  typedef enum logic [1:0] {
    MODE_FIXED     = 2'd0,
    MODE_TABLE     = 2'd1,
    MODE_PRIO      = 2'd2,
    MODE_ALT_FIXED = 2'd3
  } sched_mode_e;

  // Folds the reserved code onto the fixed rotation.
  function automatic sched_mode_e resolve_mode(input logic [1:0] raw);
    sched_mode_e m;
    case (raw)
      2'd1:    m = MODE_TABLE;
      2'd2:    m = MODE_PRIO;
      default: m = MODE_FIXED;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/sched_slot_ptr.sv
`timescale 1ns/1ps
module sched_slot_ptr #(
  parameter int NSLOT = 8
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  output logic [((NSLOT > 1) ? $clog2(NSLOT) : 1)-1:0] ptr_o,
  output logic                                   wrap_o
);
  localparam int SLOT_W = (NSLOT > 1) ? $clog2(NSLOT) : 1;
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(NSLOT - 1);

  logic [SLOT_W-1:0] ptr_q, ptr_d;

  always_comb begin
    if (ptr_q == LAST) ptr_d = '0;
    else               ptr_d = ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  assign ptr_o  = ptr_q;
  assign wrap_o = (ptr_q == LAST);
endmodule

// File: rtl/sched_mode_reg.sv
`timescale 1ns/1ps
module sched_mode_reg
  import thread_sched_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  mode_raw_i,
  input  logic        load_i,
  output sched_mode_e mode_o
);
  sched_mode_e mode_q, mode_d;
  logic        mode_en;

  assign mode_en = load_i;

  always_comb begin
    mode_d = resolve_mode(mode_raw_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= MODE_FIXED;
    else if (mode_en) mode_q <= mode_d;
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/sched_slot_table.sv
`timescale 1ns/1ps
module sched_slot_table #(
  parameter int NTHR  = 4,
  parameter int NSLOT = 8
) (
  input  logic                                        clk,
  input  logic                                        rst_n,
  input  logic                                        we_i,
  input  logic [((NSLOT > 1) ? $clog2(NSLOT) : 1)-1:0] waddr_i,
  input  logic [((NTHR > 1) ? $clog2(NTHR) : 1)-1:0]   wdata_i,
  input  logic [((NSLOT > 1) ? $clog2(NSLOT) : 1)-1:0] raddr_i,
  output logic [((NTHR > 1) ? $clog2(NTHR) : 1)-1:0]   rdata_o
);
  localparam int SLOT_W = (NSLOT > 1) ? $clog2(NSLOT) : 1;
  localparam int TID_W  = (NTHR > 1) ? $clog2(NTHR) : 1;

  logic [TID_W-1:0] ent_q [NSLOT];
  logic [NSLOT-1:0] ent_en;

  for (genvar g = 0; g < NSLOT; g++) begin : g_dec
    assign ent_en[g] = we_i && (waddr_i == SLOT_W'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSLOT; i++) ent_q[i] <= TID_W'(i % NTHR);
    end else begin
      for (int i = 0; i < NSLOT; i++) begin
        if (ent_en[i]) ent_q[i] <= wdata_i;
      end
    end
  end

  assign rdata_o = ent_q[raddr_i];
endmodule

// File: rtl/sched_prio_pick.sv
`timescale 1ns/1ps
module sched_prio_pick #(
  parameter int NTHR = 4
) (
  input  logic [NTHR-1:0]                            req_i,
  output logic                                       found_o,
  output logic [((NTHR > 1) ? $clog2(NTHR) : 1)-1:0] idx_o
);
  localparam int TID_W = (NTHR > 1) ? $clog2(NTHR) : 1;

  always_comb begin
    found_o = |req_i;
    idx_o   = '0;
    for (int i = NTHR - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = TID_W'(i);
    end
  end
endmodule

// File: rtl/thread_slot_sched.sv
`timescale 1ns/1ps
module thread_slot_sched
  import thread_sched_pkg::*;
#(
  parameter int NTHR  = 4,
  parameter int NSLOT = 8
) (
  input  logic                                        clk,
  input  logic                                        rst_n,
  input  logic [NTHR-1:0]                             ready_i,
  input  logic [1:0]                                  mode_i,
  input  logic                                        tbl_we_i,
  input  logic [((NSLOT > 1) ? $clog2(NSLOT) : 1)-1:0] tbl_addr_i,
  input  logic [((NTHR > 1) ? $clog2(NTHR) : 1)-1:0]   tbl_data_i,
  output logic                                        issue_valid_o,
  output logic [((NTHR > 1) ? $clog2(NTHR) : 1)-1:0]   issue_tid_o,
  output logic                                        bubble_o
);
  localparam int SLOT_W = (NSLOT > 1) ? $clog2(NSLOT) : 1;
  localparam int TID_W  = (NTHR > 1) ? $clog2(NTHR) : 1;

  logic [SLOT_W-1:0] ptr_q;
  logic              wrap;
  sched_mode_e       mode_q;
  logic [TID_W-1:0]  tbl_owner;
  logic [TID_W-1:0]  fix_owner;
  logic              pick_found;
  logic [TID_W-1:0]  pick_idx;
  logic [TID_W-1:0]  sel_tid;
  logic              sel_valid;

  sched_slot_ptr #(.NSLOT(NSLOT)) u_ptr (
    .clk    (clk),
    .rst_n  (rst_n),
    .ptr_o  (ptr_q),
    .wrap_o (wrap)
  );

  sched_mode_reg u_mode (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_raw_i (mode_i),
    .load_i     (wrap),
    .mode_o     (mode_q)
  );

  sched_slot_table #(.NTHR(NTHR), .NSLOT(NSLOT)) u_tbl (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (tbl_we_i),
    .waddr_i (tbl_addr_i),
    .wdata_i (tbl_data_i),
    .raddr_i (ptr_q),
    .rdata_o (tbl_owner)
  );

  sched_prio_pick #(.NTHR(NTHR)) u_pick (
    .req_i   (ready_i),
    .found_o (pick_found),
    .idx_o   (pick_idx)
  );

  // Fixed rotation owner: pointer modulo thread count.
  assign fix_owner = TID_W'(32'(ptr_q) % NTHR);

  always_comb begin
    case (mode_q)
      MODE_TABLE: begin
        sel_tid   = tbl_owner;
        sel_valid = ready_i[tbl_owner];
      end
      MODE_PRIO: begin
        sel_tid   = pick_idx;
        sel_valid = pick_found;
      end
      default: begin
        sel_tid   = fix_owner;
        sel_valid = ready_i[fix_owner];
      end
    endcase
  end

  assign issue_valid_o = sel_valid;
  assign issue_tid_o   = sel_tid;
  assign bubble_o      = ~sel_valid;
endmodule

// File: rtl/thread_slot_sched_chk.sv
`timescale 1ns/1ps
module thread_slot_sched_chk
  import thread_sched_pkg::*;
#(
  parameter int NTHR  = 4,
  parameter int NSLOT = 8
) (
  input logic                                        clk,
  input logic                                        rst_n,
  input logic [NTHR-1:0]                             ready_i,
  input logic [1:0]                                  mode_q,
  input logic [((NSLOT > 1) ? $clog2(NSLOT) : 1)-1:0] ptr_q,
  input logic                                        issue_valid_o,
  input logic [((NTHR > 1) ? $clog2(NTHR) : 1)-1:0]   issue_tid_o
);
  logic [1:0] warm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             warm_q <= 2'd0;
    else if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
  end

  // R2: fixed rotation advances one thread per cycle
  a_r2_fixed_step: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q == 2'd2 && mode_q == MODE_FIXED && $past(mode_q) == MODE_FIXED)
      |-> (int'(issue_tid_o) == ((int'($past(issue_tid_o)) + 1) % NTHR)));

  // R3: an issued thread is always ready
  a_r3_issue_ready: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid_o |-> ready_i[issue_tid_o]);

  // R6: no lower-numbered thread is ready when priority issues
  a_r6_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_PRIO && issue_valid_o)
      |-> ((ready_i & ((NTHR'(1) << issue_tid_o) - NTHR'(1))) == '0));

  // R6: priority never wastes a cycle when some thread is ready
  a_r6_no_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_PRIO && ready_i != '0) |-> issue_valid_o);

  // R7: policy only changes as the pointer lands on 0
  a_r7_mode_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q == 2'd2 && ptr_q != '0) |-> $stable(mode_q));

  // R4: pointer steps by one and wraps after the last slot
  a_r4_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q == 2'd2)
      |-> (int'(ptr_q) == ((int'($past(ptr_q)) + 1) % NSLOT)));
endmodule

bind thread_slot_sched thread_slot_sched_chk #(.NTHR(NTHR), .NSLOT(NSLOT)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .ready_i       (ready_i),
  .mode_q        (mode_q),
  .ptr_q         (ptr_q),
  .issue_valid_o (issue_valid_o),
  .issue_tid_o   (issue_tid_o)
);

// File: tb/test_thread_slot_sched.sv
`timescale 1ns/1ps
module test_thread_slot_sched;
  localparam int NTHR   = 4;
  localparam int NSLOT  = 8;
  localparam int TID_W  = 2;
  localparam int SLOT_W = 3;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic              rst_n;
  logic [NTHR-1:0]   ready;
  logic [1:0]        mode;
  logic              we;
  logic [SLOT_W-1:0] waddr;
  logic [TID_W-1:0]  wdata;
  logic              issue_valid;
  logic              bubble;
  logic [TID_W-1:0]  tid;

  int checks   = 0;
  int failures = 0;
  int m_ptr;
  int m_mode;
  int m_tbl [NSLOT];

  thread_slot_sched #(.NTHR(NTHR), .NSLOT(NSLOT)) i_thread_slot_sched (
    .clk           (clk),
    .rst_n         (rst_n),
    .ready_i       (ready),
    .mode_i        (mode),
    .tbl_we_i      (we),
    .tbl_addr_i    (waddr),
    .tbl_data_i    (wdata),
    .issue_valid_o (issue_valid),
    .issue_tid_o   (tid),
    .bubble_o      (bubble)
  );

  function automatic int eff_mode(int m);
    return (m == 1 || m == 2) ? m : 0;
  endfunction

  // Expected output encoded as valid*16 + tid.
  function automatic int exp_out(int md, int p, logic [NTHR-1:0] rd);
    int t;
    case (eff_mode(md))
      1: begin
        t = m_tbl[p];
        return (rd[t] ? 16 : 0) + t;
      end
      2: begin
        for (int i = 0; i < NTHR; i++) if (rd[i]) return 16 + i;
        return 0;
      end
      default: begin
        t = p % NTHR;
        return (rd[t] ? 16 : 0) + t;
      end
    endcase
  endfunction

  task automatic check(string tag, int got, int exp, string what);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s %s got=%0d exp=%0d (ptr=%0d mode=%0d)", tag, what, got, exp, m_ptr, m_mode);
    end
  endtask

  // Called at a negative edge with inputs already set.
  task automatic step(string tag_in);
    int    e;
    int    got;
    string tag;
    #1;
    e   = exp_out(m_mode, m_ptr, ready);
    got = (issue_valid ? 16 : 0) + int'(tid);
    if (tag_in != "")            tag = tag_in;
    else if (eff_mode(m_mode) == 1) tag = "R4";
    else if (eff_mode(m_mode) == 2) tag = "R6";
    else if (e < 16)              tag = "R3";
    else                          tag = "R2";
    check(tag, got, e, "valid*16+tid");
    check("R10", int'(bubble), (e >= 16) ? 0 : 1, "bubble");
    @(posedge clk);
    if (we) m_tbl[waddr] = int'(wdata);
    if (m_ptr == NSLOT - 1) m_mode = int'(mode);
    m_ptr = (m_ptr + 1) % NSLOT;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd4321));
    rst_n = 1'b0;
    ready = '0;
    mode  = 2'd0;
    we    = 1'b0;
    waddr = '0;
    wdata = '0;
    repeat (3) @(negedge clk);
    rst_n  = 1'b1;
    m_ptr  = 0;
    m_mode = 0;
    for (int i = 0; i < NSLOT; i++) m_tbl[i] = i % NTHR;

    // R1: reset state, slot 0 owned by thread 0
    ready = '1;
    #1;
    check("R1", (issue_valid ? 16 : 0) + int'(tid), 16, "reset slot 0");
    #0;

    // R2: all ready, pure fixed order
    step(""); step(""); step("");
    // R7: request priority mid-frame, lone ready thread 3
    mode  = 2'd2;
    ready = 4'b1000;
    step("R7");           // ptr 3: owner 3 issues
    step("R7");           // ptr 4: owner 0 not ready -> bubble
    step(""); step(""); step("");
    step("R7");           // ptr 0, priority now: thread 3 issues

    // R6: nobody ready -> bubble, then lowest ready wins
    ready = 4'b0000; step("R6");
    ready = 4'b0110; step("R6");
    // R9: same-cycle response to ready change
    ready = 4'b0100; step("R9");
    ready = 4'b0010; step("R9");

    // Switch to table mode, check reset table contents (R1)
    mode  = 2'd1;
    ready = '1;
    step("");
    while (m_ptr != 0) step("");
    for (int k = 0; k < NSLOT; k++) step("R1");

    // R5: write next slot to thread 3, takes effect next cycle
    we    = 1'b1;
    waddr = SLOT_W'((m_ptr + 1) % NSLOT);
    wdata = 2'd3;
    step("R4");
    we = 1'b0;
    step("R5");
    // R3 in table mode: owner not ready -> bubble
    ready = 4'b0111;
    for (int k = 0; k < NSLOT; k++) step("");

    // R8: reserved code acts as fixed rotation
    mode  = 2'd3;
    ready = '1;
    step("");
    while (m_ptr != 0) step("");
    for (int k = 0; k < NSLOT; k++) step("R8");

    // Random traffic
    for (int n = 0; n < 800; n++) begin
      ready = NTHR'($urandom);
      we    = ($urandom % 4) == 0;
      waddr = SLOT_W'($urandom);
      wdata = TID_W'($urandom);
      if (($urandom % 40) == 0) mode = 2'($urandom);
      step("");
    end
    we = 1'b0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule